// File: doc/BRIEF.md
# Raster Timing Generator with Sprite-Table Access Window

This block is the raster scanner of a 15 kHz-class arcade display. It advances a horizontal pixel counter on every pixel-clock enable and a vertical line counter each time a line ends. From those two counters it derives active-low horizontal and vertical sync, a blanking flag, and two flags that the sprite scanner uses. One flag marks the band of lines where sprites are fetched, which is the scrolling part of the picture. The other splits the visible picture into an upper and a lower half, so the scanner can pick a different attribute region for each half.

The frame is deliberately taller than a broadcast frame: 384 pixel clocks by 282 lines. The extra lines give the CPU enough fly-back time to rewrite every sprite entry. The block also produces a grant for CPU access to sprite attribute RAM. The grant is high on every line outside the sprite band, so the CPU is not limited to vertical blank. The sprite band sits at the top or the bottom of the visible area, depending on the flip-screen input. The grant is re-evaluated only at a line boundary, so a CPU access window never opens or closes while the scanner is in the middle of a line.

All outputs are plain level signals. The block has no data stream, so it has no valid/ready handshake and takes no back-pressure. A pixel enable that is held low freezes the whole scanner.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is asserted and right after it is released, both counters read 0, `cpu_grant` is 0, both sync outputs are high and `blank` is 0.
- R2: `hcount` increments by one on each clock with `pix_ce` high and goes from H_TOTAL-1 (383) back to 0. When `pix_ce` is low, neither counter changes.
- R3: `vcount` increments by one only on the `pix_ce` clock where `hcount` wraps, and goes from V_TOTAL-1 (281) back to 0. A frame is therefore 282 lines.
- R4: `hsync_n` is 0 exactly while `hcount` is in 288..319, which is 32 pixel clocks, and is 1 otherwise.
- R5: `vsync_n` is 0 exactly while `vcount` is in 264..266, which is 3 lines, and is 1 otherwise.
- R6: `blank` is 1 exactly when `hcount` >= 256 or `vcount` >= 256.
- R7: With `flip_en`=0, `spr_zone` is 1 for lines 64..255. With `flip_en`=1, it is 1 for lines 0..191. On all other lines it is 0. The flag follows `flip_en` within the same cycle.
- R8: `lower_half` is 1 exactly for lines 128..255.
- R9: `cpu_grant` changes only on the `pix_ce` clock where `hcount` wraps. On that clock it takes the inverse of the sprite-zone test for the new line number, using the `flip_en` level present at that clock. It then holds for the whole line, even if `flip_en` changes during the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Pixel-clock enable (6 MHz rate) |
| flip_en | input | 1 | Flip-screen state |
| hcount | output | 9 | Horizontal pixel counter |
| vcount | output | 9 | Vertical line counter |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the 256x256 visible area |
| spr_zone | output | 1 | Current line lies in the sprite band |
| lower_half | output | 1 | Current line lies in the lower visible half |
| cpu_grant | output | 1 | CPU may access sprite attribute RAM this line |

## Verification
The hardest case to reach is a `flip_en` change in the middle of a line, right where the sprite band starts or ends. In that case `spr_zone` must move at once, while `cpu_grant` must keep the value it latched at the start of the line until the next wrap. The bench builds the design with a shrunken frame so that several whole frames fit in a short run. It toggles `flip_en` at irregular cycle counts that fall at many different positions within a line, and it gates `pix_ce` in a fixed irregular pattern. It compares every output on every cycle against an arithmetic model of the counters.

// File: rtl/raster_pkg.sv
package raster_pkg;
  // inclusive span test shared by sync, zone and half decoders
  function automatic logic in_span(input int val, input int lo, input int hi);
    return (val >= lo) && (val <= hi);
  endfunction
endpackage

// File: rtl/raster_axis.sv
module raster_axis #(
  parameter int TOTAL      = 384,
  parameter int VIS        = 256,
  parameter int SYNC_START = 288,
  parameter int SYNC_W     = 32,
  localparam int W         = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic         last,
  output logic [W-1:0] count,
  output logic         sync_n,
  output logic         active
);
  import raster_pkg::*;

  localparam int SYNC_END = SYNC_START + SYNC_W - 1;

  logic [W-1:0] cnt_q;

  assign last = (cnt_q == W'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= last ? '0 : cnt_q + W'(1);
    end
  end

  assign count  = cnt_q;
  assign sync_n = !in_span(int'(cnt_q), SYNC_START, SYNC_END);
  assign active = int'(cnt_q) < VIS;
endmodule

// File: rtl/sprite_gate.sv
module sprite_gate #(
  parameter int V_TOTAL = 282,
  parameter int V_VIS   = 256,
  parameter int ZONE_LO = 64,
  localparam int VW     = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_adv,
  input  logic [VW-1:0] vcount,
  input  logic          flip_en,
  output logic          spr_zone,
  output logic          lower_half,
  output logic          cpu_grant
);
  import raster_pkg::*;

  localparam int HALF    = V_VIS / 2;
  localparam int FLIP_HI = V_VIS - 1 - ZONE_LO;

  function automatic logic zone_of(input logic [VW-1:0] v, input logic flip);
    return flip ? in_span(int'(v), 0, FLIP_HI) : in_span(int'(v), ZONE_LO, V_VIS - 1);
  endfunction

  logic [VW-1:0] v_next;
  logic          grant_q;

  assign v_next = (vcount == VW'(V_TOTAL - 1)) ? '0 : vcount + VW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
    end else if (line_adv) begin
      grant_q <= !zone_of(v_next, flip_en);
    end
  end

  assign spr_zone   = zone_of(vcount, flip_en);
  assign lower_half = in_span(int'(vcount), HALF, V_VIS - 1);
  assign cpu_grant  = grant_q;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int H_TOTAL    = 384,
  parameter int H_VIS      = 256,
  parameter int H_SYNC_POS = 288,
  parameter int H_SYNC_W   = 32,
  parameter int V_TOTAL    = 282,
  parameter int V_VIS      = 256,
  parameter int V_SYNC_POS = 264,
  parameter int V_SYNC_W   = 3,
  parameter int ZONE_LO    = 64,
  localparam int HW        = $clog2(H_TOTAL),
  localparam int VW        = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_ce,
  input  logic          flip_en,
  output logic [HW-1:0] hcount,
  output logic [VW-1:0] vcount,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          blank,
  output logic          spr_zone,
  output logic          lower_half,
  output logic          cpu_grant
);
  logic h_last, v_last, h_act, v_act, line_adv;

  assign line_adv = pix_ce & h_last;

  raster_axis #(
    .TOTAL(H_TOTAL), .VIS(H_VIS), .SYNC_START(H_SYNC_POS), .SYNC_W(H_SYNC_W)
  ) u_haxis (
    .clk(clk), .rst_n(rst_n), .step(pix_ce), .last(h_last),
    .count(hcount), .sync_n(hsync_n), .active(h_act)
  );

  raster_axis #(
    .TOTAL(V_TOTAL), .VIS(V_VIS), .SYNC_START(V_SYNC_POS), .SYNC_W(V_SYNC_W)
  ) u_vaxis (
    .clk(clk), .rst_n(rst_n), .step(line_adv), .last(v_last),
    .count(vcount), .sync_n(vsync_n), .active(v_act)
  );

  sprite_gate #(
    .V_TOTAL(V_TOTAL), .V_VIS(V_VIS), .ZONE_LO(ZONE_LO)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .line_adv(line_adv), .vcount(vcount),
    .flip_en(flip_en), .spr_zone(spr_zone), .lower_half(lower_half),
    .cpu_grant(cpu_grant)
  );

  assign blank = !(h_act && v_act);

  logic unused_v_last;
  assign unused_v_last = v_last;
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int H_TOTAL = 384,
  parameter int V_TOTAL = 282,
  localparam int HW     = $clog2(H_TOTAL),
  localparam int VW     = $clog2(V_TOTAL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_ce,
  input logic [HW-1:0] hcount,
  input logic [VW-1:0] vcount,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          blank,
  input logic          cpu_grant
);
  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ce && hcount == HW'(H_TOTAL - 1)) |=> (hcount == '0)); // R2

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ce |=> ($stable(hcount) && $stable(vcount))); // R2

  AST_V_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ce && hcount != HW'(H_TOTAL - 1)) |=> $stable(vcount)); // R3

  AST_V_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vcount) < V_TOTAL); // R3

  AST_HSYNC_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> blank); // R4

  AST_VSYNC_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> blank); // R5

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_ce && hcount == HW'(H_TOTAL - 1)) |=> $stable(cpu_grant)); // R9

  AST_GRANT_AT_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(cpu_grant) |-> (hcount == '0)); // R9
endmodule

bind raster_timing_gen raster_timing_chk #(
  .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .hcount(hcount), .vcount(vcount),
  .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank), .cpu_grant(cpu_grant)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
  localparam int HT = 48, HV = 32, HSP = 36, HSW = 4;
  localparam int VT = 40, VV = 32, VSP = 34, VSW = 3, ZLO = 8;
  localparam int HW = $clog2(HT), VW = $clog2(VT);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_ce = 1'b0;
  logic flip_en = 1'b0;
  logic [HW-1:0] hcount;
  logic [VW-1:0] vcount;
  logic hsync_n, vsync_n, blank, spr_zone, lower_half, cpu_grant;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  raster_timing_gen #(
    .H_TOTAL(HT), .H_VIS(HV), .H_SYNC_POS(HSP), .H_SYNC_W(HSW),
    .V_TOTAL(VT), .V_VIS(VV), .V_SYNC_POS(VSP), .V_SYNC_W(VSW), .ZONE_LO(ZLO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .flip_en(flip_en),
    .hcount(hcount), .vcount(vcount), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .blank(blank), .spr_zone(spr_zone), .lower_half(lower_half), .cpu_grant(cpu_grant)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (h=%0d v=%0d)", req, act, exp, hcount, vcount);
    end
  endtask

  function automatic bit zone_m(input int v, input bit f);
    return f ? (v <= VV - 1 - ZLO) : (v >= ZLO && v < VV);
  endfunction

  int eh = 0, ev = 0;
  bit eg = 1'b0;

  task automatic compare_all();
    check("R2 hcount", int'(hcount), eh);
    check("R3 vcount", int'(vcount), ev);
    check("R4 hsync_n", int'(hsync_n), (eh >= HSP && eh < HSP + HSW) ? 0 : 1);
    check("R5 vsync_n", int'(vsync_n), (ev >= VSP && ev < VSP + VSW) ? 0 : 1);
    check("R6 blank", int'(blank), (eh >= HV || ev >= VV) ? 1 : 0);
    check("R7 spr_zone", int'(spr_zone), int'(zone_m(ev, flip_en)));
    check("R8 lower_half", int'(lower_half), (ev >= VV / 2 && ev < VV) ? 1 : 0);
    check("R9 cpu_grant", int'(cpu_grant), int'(eg));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 hcount", int'(hcount), 0);
    check("R1 vcount", int'(vcount), 0);
    check("R1 cpu_grant", int'(cpu_grant), 0);
    check("R1 hsync_n", int'(hsync_n), 1);
    check("R1 vsync_n", int'(vsync_n), 1);
    check("R1 blank", int'(blank), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release h", int'(hcount), 0);
    check("R1 after release grant", int'(cpu_grant), 0);
    // sweep five frames with gated pix_ce and irregular flip toggles
    for (int cyc = 0; cyc < 12500; cyc++) begin
      compare_all();
      pix_ce = (cyc % 7 != 3) && (cyc % 11 != 5);
      if (cyc % 613 == 200) flip_en = !flip_en;
      if (pix_ce) begin
        if (eh == HT - 1) begin
          eh = 0;
          ev = (ev == VT - 1) ? 0 : ev + 1;
          eg = !zone_m(ev, flip_en);
        end else begin
          eh = eh + 1;
        end
      end
      @(negedge clk);
    end
    compare_all();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule